// File: doc/BRIEF.md
# Card Register and Interrupt Logic

This block is the host-facing register slice of a data acquisition card. It decodes host writes that come with a valid-write strobe. A write to the ID location starts a soft reset of the card. A write to the status location can only change the interrupt enable bit. A write to the pace location loads the interval that paces conversions.

The block presents a status word at all times. The word carries the interrupt enable, the two-bit strapped interrupt level and the converter busy flag. The strapped level picks one of four interrupt request lines, which stand for levels 3 to 6. That line is raised only while interrupts are enabled and the converter is idle.

Top module: `card_reg_irq`

## Requirements
- R1: Writes take effect only at three addresses: ID = 0, status = 1 and pace = 2. A strobed write to address 3 changes neither the enable bit nor the pace register.
- R2: A strobed write to the ID address has three effects on the next cycle: the enable bit is cleared, the pace register holds PACE_MIN, and soft_rst_o is high for exactly that one cycle.
- R3: A strobed write to the status address sets the interrupt enable to wdata_i[7]. From the cycle after the write, status_o[7] shows the enable.
- R4: On a status write, bits 6..0 of wdata_i are ignored. They affect neither status_o nor irq_o.
- R5: status_o[5:4] equals level_i in every cycle.
- R6: status_o[0] equals busy_i. Bits 6, 3, 2 and 1 of status_o read zero.
- R7: A strobed write to the pace address loads wdata_i into pace_o, which is visible the next cycle. With wr_i low, no write has any effect.
- R8: irq_o has at most one bit set. When a request is active, the set bit is irq_o[level_i]: level code 0 maps to level 3 and code 3 maps to level 6.
- R9: irq_o is nonzero exactly when the enable bit is 1 and busy_i is 0. It follows busy_i with no clock delay.
- R10: After rst_ni is asserted, the enable bit is 0, pace_o equals PACE_MIN, soft_rst_o is 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Valid-write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Host write data |
| level_i | input | 2 | Strapped interrupt level code |
| busy_i | input | 1 | Converter busy |
| status_o | output | 8 | Status word |
| pace_o | output | 8 | Pace interval register |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| irq_o | output | 4 | Interrupt requests for levels 3..6 |

## Verification
Register effects are due one edge after a strobed write. These are the enable bit, the pace value and the soft reset pulse. The bench applies each write on a falling edge, lets the next rising edge capture it, and compares on the falling edge that follows. The status bits for level and busy, and the whole interrupt decode, have no clock delay. The bench changes level_i and busy_i on a falling edge and compares a few nanoseconds later, within the same low phase.

// File: rtl/card_pkg.sv
package card_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LVL_W  = 2;
  localparam int unsigned N_IRQ  = 1 << LVL_W;

  localparam logic [ADDR_W-1:0] A_ID   = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_PACE = 2'd2;

  // status word bit positions
  localparam int unsigned S_BUSY  = 0;
  localparam int unsigned S_LVL   = 4;
  localparam int unsigned S_EN    = 7;

  typedef struct packed {
    logic id;
    logic stat;
    logic pace;
  } wr_sel_t;
endpackage

// File: rtl/card_wr_decode.sv
module card_wr_decode
  import card_pkg::*;
(
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_sel_t           sel_o
);
  always_comb begin
    sel_o      = '0;
    sel_o.id   = wr_i && (addr_i == A_ID);
    sel_o.stat = wr_i && (addr_i == A_STAT);
    sel_o.pace = wr_i && (addr_i == A_PACE);
  end
endmodule

// File: rtl/card_ctrl_regs.sv
module card_ctrl_regs
  import card_pkg::*;
#(
  parameter int unsigned PACE_W = 8,
  parameter logic [PACE_W-1:0] PACE_MIN = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_sel_t           sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic [PACE_W-1:0] pace_o,
  output logic              soft_rst_o
);
  logic              en_q;
  logic [PACE_W-1:0] pace_q;
  logic              soft_q;

  // the soft reset wins over any other write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pace_q <= PACE_MIN;
      soft_q <= 1'b0;
    end else begin
      soft_q <= sel_i.id;
      if (sel_i.id) begin
        en_q   <= 1'b0;
        pace_q <= PACE_MIN;
      end else begin
        if (sel_i.stat) en_q   <= wdata_i[S_EN];
        if (sel_i.pace) pace_q <= wdata_i[PACE_W-1:0];
      end
    end
  end

  assign en_o       = en_q;
  assign pace_o     = pace_q;
  assign soft_rst_o = soft_q;

  p_soft_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i.id |=> (!en_q && pace_q == PACE_MIN && soft_q));
  p_en_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i.id || sel_i.stat) |=> $stable(en_q));
  p_pace_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i.id || sel_i.pace) |=> $stable(pace_q));
  p_en_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i.stat && !sel_i.id) |=> (en_q == $past(wdata_i[S_EN])));
endmodule

// File: rtl/card_irq_out.sv
module card_irq_out
  import card_pkg::*;
(
  input  logic              en_i,
  input  logic              busy_i,
  input  logic [LVL_W-1:0]  level_i,
  output logic [N_IRQ-1:0]  irq_o,
  output logic [DATA_W-1:0] status_o
);
  logic gate;
  assign gate = en_i && !busy_i;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    assign irq_o[g] = gate && (level_i == LVL_W'(g));
  end

  always_comb begin
    status_o                    = '0;
    status_o[S_EN]              = en_i;
    status_o[S_LVL+:LVL_W]      = level_i;
    status_o[S_BUSY]            = busy_i;
  end

  always_comb begin
    p_irq_onehot_r8: assert ($onehot0(irq_o));
  end
endmodule

// File: rtl/card_reg_irq.sv
module card_reg_irq
  import card_pkg::*;
#(
  parameter int unsigned PACE_W = 8,
  parameter logic [PACE_W-1:0] PACE_MIN = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [1:0]        level_i,
  input  logic              busy_i,
  output logic [7:0]        status_o,
  output logic [PACE_W-1:0] pace_o,
  output logic              soft_rst_o,
  output logic [3:0]        irq_o
);
  wr_sel_t sel;
  logic    en;

  card_wr_decode u_dec (
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  card_ctrl_regs #(.PACE_W(PACE_W), .PACE_MIN(PACE_MIN)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .wdata_i    (wdata_i),
    .en_o       (en),
    .pace_o     (pace_o),
    .soft_rst_o (soft_rst_o)
  );

  card_irq_out u_irq (
    .en_i     (en),
    .busy_i   (busy_i),
    .level_i  (level_i),
    .irq_o    (irq_o),
    .status_o (status_o)
  );

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> (status_o[S_EN] && !busy_i));
  p_irq_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> irq_o[level_i]);
  p_soft_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> !status_o[S_EN]);
endmodule

// File: tb/card_reg_irq_test.sv
module card_reg_irq_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [1:0] level_i = '0;
  logic       busy_i = 1'b1;
  logic [7:0] status_o;
  logic [7:0] pace_o;
  logic       soft_rst_o;
  logic [3:0] irq_o;

  localparam logic [7:0] PMIN = 8'h01;
  int checks = 0;
  int fails = 0;
  logic exp_en = 1'b0;
  logic [7:0] exp_pace = PMIN;

  always #10 clk = ~clk;

  card_reg_irq uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .level_i(level_i), .busy_i(busy_i),
    .status_o(status_o), .pace_o(pace_o), .soft_rst_o(soft_rst_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_irq();
    return (exp_en && !busy_i) ? (4'b0001 << level_i) : 4'b0000;
  endfunction

  function automatic logic [7:0] exp_stat();
    return {exp_en, 1'b0, level_i, 3'b000, busy_i};
  endfunction

  // drive on falling edge, capture at rising, compare at next falling
  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic strobe);
    @(negedge clk);
    wr_i = strobe; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
    #1;
  endtask

  task automatic check_all(input string req);
    chk(req, {24'b0, status_o}, {24'b0, exp_stat()});
    chk(req, {24'b0, pace_o}, {24'b0, exp_pace});
    chk(req, {28'b0, irq_o}, {28'b0, exp_irq()});
  endtask

  initial begin
    #200_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 pace", {24'b0, pace_o}, {24'b0, PMIN});
    chk("R10 en", {31'b0, status_o[7]}, 32'd0);
    chk("R10 soft", {31'b0, soft_rst_o}, 32'd0);
    chk("R10 irq", {28'b0, irq_o}, 32'd0);
    rst_ni = 1'b1;

    // R7: every pace value
    for (int v = 0; v < 256; v++) begin
      wr(2'd2, 8'(v), 1'b1);
      exp_pace = 8'(v);
      chk("R7 pace load", {24'b0, pace_o}, {24'b0, exp_pace});
    end

    // R7 no strobe, R1 unused address
    for (int a = 0; a < 4; a++) begin
      wr(2'(a), 8'hA5, 1'b0);
      check_all("R7 no strobe");
    end
    wr(2'd1, 8'h80, 1'b1); exp_en = 1'b1;
    wr(2'd3, 8'h00, 1'b1);
    check_all("R1 unused addr");
    wr(2'd3, 8'hFF, 1'b1);
    check_all("R1 unused addr");

    // R3/R4: all status write data
    busy_i = 1'b0;
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, 8'(v), 1'b1);
      exp_en = v[7];
      chk("R3 en bit", {31'b0, status_o[7]}, {31'b0, exp_en});
      chk("R4 ignored bits", {24'b0, status_o}, {24'b0, exp_stat()});
    end

    // R5/R6/R8/R9: sweep enable x busy x level, combinational
    for (int e = 0; e < 2; e++) begin
      wr(2'd1, {e[0], 7'h00}, 1'b1); exp_en = e[0];
      for (int b = 0; b < 2; b++) begin
        for (int l = 0; l < 4; l++) begin
          @(negedge clk);
          busy_i = b[0]; level_i = 2'(l);
          #2;
          chk("R5 level", {30'b0, status_o[5:4]}, {30'b0, level_i});
          chk("R6 status", {24'b0, status_o}, {24'b0, exp_stat()});
          chk("R8 R9 irq", {28'b0, irq_o}, {28'b0, exp_irq()});
        end
      end
    end

    // R9: same-cycle deassert on busy rise
    wr(2'd1, 8'h80, 1'b1); exp_en = 1'b1;
    @(negedge clk); busy_i = 1'b0; level_i = 2'd2; #2;
    chk("R9 active", {28'b0, irq_o}, 32'h4);
    busy_i = 1'b1; #1;
    chk("R9 busy rise", {28'b0, irq_o}, 32'h0);
    busy_i = 1'b0;

    // R2: soft reset
    wr(2'd2, 8'h3C, 1'b1); exp_pace = 8'h3C;
    wr(2'd0, 8'hFF, 1'b1);
    exp_en = 1'b0; exp_pace = PMIN;
    chk("R2 soft pulse", {31'b0, soft_rst_o}, 32'd1);
    check_all("R2 soft clear");
    @(negedge clk); #1;
    chk("R2 pulse width", {31'b0, soft_rst_o}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule